// File: doc/BRIEF.md
# MSI Coherence Directory Controller

This block is the home-node directory for a three-state (Modified, Shared, Invalid) cache coherence protocol serving up to eight private caches. For every line it keeps a stable or transient state, a one-hot owner vector and a sharer bit-vector. Caches send it read-for-share, read-for-ownership and writeback requests. Caches also return line data when the directory has forwarded a read to the line's owner. The directory issues reads and writes to a memory port and takes back memory read data and write acknowledgements. Toward the caches it sends data with an ack count, requests forwarded to the current owner, multicast invalidations and writeback acknowledgements.

The entry table is direct-mapped with one entry per line address, so no tag compare is needed. Three input queues (memory replies, cache responses, cache requests) are valid/ready streams. At most one message is accepted per clock, in fixed priority: memory first, then responses, then requests. A message moves only when its valid and ready are both high on a rising edge. The ready of an input may depend on its valid. The two output streams (cache message and memory operation) are single registers. A valid output holds all of its fields until ready is seen. No input is accepted unless each output register is empty or draining in that cycle. A request to a line in a transient state keeps its ready low and stays at the head of its queue. The other two queues keep flowing.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid with no owner and no sharers, and neither output stream is valid.
- R2: A read-for-share (request code 0) to a line in Invalid or Shared issues a memory read (write flag 0) and adds the requester to the sharers. The memory read data then goes to the requester as a Data message (message code 0) with ack count 0, and the line becomes Shared.
- R3: A read-for-ownership (request code 1) to a line in Invalid or Shared removes the requester from the sharer set first. It then sends one invalidation (message code 3) whose destination vector holds the remaining sharers, if any, and issues a memory read. The Data later sent to the requester carries the number of remaining sharers as its ack count, and the line becomes Modified with that requester as sole owner.
- R4: A read-for-ownership to a Modified line sends a forwarded ownership request (message code 2) to the old owner only. The requester replaces the old owner, so the line keeps exactly one owner.
- R5: A read-for-share to a Modified line sends a forwarded share request (message code 1) to the owner and makes owner and requester sharers with no owner. The owner's data response is written to memory. The write acknowledgement makes the line Shared.
- R6: A writeback (request code 2) from the recorded owner of a Modified line writes its data to memory and sends a writeback ack (message code 4). The write acknowledgement makes the line Invalid. A writeback from any other cache gets only the writeback ack and leaves the line unchanged.
- R7: A request whose line is in a transient state is not accepted until the line settles, and it does not stop memory replies or responses from being accepted.
- R8: At most one input is accepted per clock, in the priority memory reply, then cache response, then request. None is accepted while an output register is full and not draining.
- R9: Forwarded requests and invalidations carry the requesting cache in the requestor field. A valid output keeps every field stable until its ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_type | input | 3 | 0 read-for-share, 1 read-for-ownership, 2 writeback |
| req_src | input | SRC_W | Requesting cache index |
| req_addr | input | ADDR_W | Line address |
| req_data | input | DATA_W | Writeback data |
| rsp_valid | input | 1 | Cache response valid |
| rsp_ready | output | 1 | Cache response accepted |
| rsp_src | input | SRC_W | Responding cache index |
| rsp_addr | input | ADDR_W | Line address |
| rsp_data | input | DATA_W | Line data from the owner |
| mem_in_valid | input | 1 | Memory reply valid |
| mem_in_ready | output | 1 | Memory reply accepted |
| mem_in_ack | input | 1 | 1 write acknowledgement, 0 read data |
| mem_in_addr | input | ADDR_W | Line address |
| mem_in_data | input | DATA_W | Read data |
| mem_out_valid | output | 1 | Memory operation valid |
| mem_out_ready | input | 1 | Memory takes the operation |
| mem_out_write | output | 1 | 1 write, 0 read |
| mem_out_addr | output | ADDR_W | Line address |
| mem_out_data | output | DATA_W | Write data |
| out_valid | output | 1 | Cache message valid |
| out_ready | input | 1 | Network takes the message |
| out_type | output | 3 | 0 Data, 1 forwarded share, 2 forwarded ownership, 3 invalidate, 4 writeback ack |
| out_dest | output | NC | Destination cache vector |
| out_requestor | output | SRC_W | Originating requester |
| out_addr | output | ADDR_W | Line address |
| out_data | output | DATA_W | Line data (Data messages) |
| out_acks | output | ACK_W | Signed ack count (Data messages) |

## Verification
The assertions assume that input fields stay stable while valid waits for ready. They also assume that each memory operation gets exactly one reply of the matching kind, and that a cache response for a line comes only after a forwarded share request for that line. The bench acts as memory with a FIFO that replies only to operations it has accepted. Its cache agent returns data only for forwarded share requests, from the cache that message addressed. Requests are random over four caches and four lines, which yields stalls on transient lines, stale writebacks and multi-sharer invalidations. Random back-pressure on both output streams exercises holding and the slot gating of inputs.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;

  typedef enum logic [2:0] {
    LN_I   = 3'd0,
    LN_S   = 3'd1,
    LN_M   = 3'd2,
    LN_SM  = 3'd3,  // share read waiting for memory data
    LN_MM  = 3'd4,  // ownership read waiting for memory data
    LN_SD  = 3'd5,  // waiting for owner data after forwarded share
    LN_SW  = 3'd6,  // owner data written, waiting write ack
    LN_MIM = 3'd7   // writeback written, waiting write ack
  } line_st_e;

  typedef enum logic [2:0] {
    RQ_GETS = 3'd0,
    RQ_GETM = 3'd1,
    RQ_PUTM = 3'd2
  } req_kind_e;

  typedef enum logic [2:0] {
    OM_DATA     = 3'd0,
    OM_FWD_GETS = 3'd1,
    OM_FWD_GETM = 3'd2,
    OM_INV      = 3'd3,
    OM_PUT_ACK  = 3'd4
  } out_kind_e;

  typedef enum logic [1:0] {
    SK_NONE = 2'd0,
    SK_MEM  = 2'd1,
    SK_RSP  = 2'd2,
    SK_REQ  = 2'd3
  } src_kind_e;

  function automatic logic is_transient(line_st_e s);
    return (s == LN_SM) || (s == LN_MM) || (s == LN_SD) ||
           (s == LN_SW) || (s == LN_MIM);
  endfunction

endpackage

// File: rtl/msi_dir_pick.sv
module msi_dir_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] want,
  input  logic         slots_ok,
  output logic [N-1:0] grant
);
  // index 0 has the highest priority
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (want[i] && !taken && slots_ok) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/msi_dir_table.sv
module msi_dir_table
  import msi_dir_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int NC    = 8,
  parameter int SRC_W = 3,
  parameter int ACK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_e         rd_st,
  output logic [NC-1:0]    rd_own,
  output logic [NC-1:0]    rd_shr,
  output logic [SRC_W-1:0] rd_pend,
  output logic [ACK_W-1:0] rd_pack,
  input  logic [IDX_W-1:0] peek_idx,
  output line_st_e         peek_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_e         wr_st,
  input  logic [NC-1:0]    wr_own,
  input  logic [NC-1:0]    wr_shr,
  input  logic [SRC_W-1:0] wr_pend,
  input  logic [ACK_W-1:0] wr_pack
);
  line_st_e         st_q   [LINES];
  logic [NC-1:0]    own_q  [LINES];
  logic [NC-1:0]    shr_q  [LINES];
  logic [SRC_W-1:0] pend_q [LINES];
  logic [ACK_W-1:0] pack_q [LINES];

  assign rd_st   = st_q[rd_idx];
  assign rd_own  = own_q[rd_idx];
  assign rd_shr  = shr_q[rd_idx];
  assign rd_pend = pend_q[rd_idx];
  assign rd_pack = pack_q[rd_idx];
  assign peek_st = st_q[peek_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LN_I;
        own_q[i]  <= '0;
        shr_q[i]  <= '0;
        pend_q[i] <= '0;
        pack_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]   <= wr_st;
      own_q[wr_idx]  <= wr_own;
      shr_q[wr_idx]  <= wr_shr;
      pend_q[wr_idx] <= wr_pend;
      pack_q[wr_idx] <= wr_pack;
    end
  end
endmodule

// File: rtl/msi_dir_step.sv
module msi_dir_step
  import msi_dir_pkg::*;
#(
  parameter int NC     = 8,
  parameter int SRC_W  = 3,
  parameter int DATA_W = 32,
  parameter int ACK_W  = 4
) (
  input  src_kind_e         kind,
  input  logic [2:0]        req_type,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [DATA_W-1:0] req_data,
  input  logic [SRC_W-1:0]  rsp_src,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  input  line_st_e          cur_st,
  input  logic [NC-1:0]     cur_own,
  input  logic [NC-1:0]     cur_shr,
  input  logic [SRC_W-1:0]  cur_pend,
  input  logic [ACK_W-1:0]  cur_pack,
  output logic              wr_en,
  output line_st_e          nx_st,
  output logic [NC-1:0]     nx_own,
  output logic [NC-1:0]     nx_shr,
  output logic [SRC_W-1:0]  nx_pend,
  output logic [ACK_W-1:0]  nx_pack,
  output logic              om_go,
  output logic [2:0]        om_type,
  output logic [NC-1:0]     om_dest,
  output logic [SRC_W-1:0]  om_req,
  output logic [DATA_W-1:0] om_data,
  output logic [ACK_W-1:0]  om_acks,
  output logic              mm_go,
  output logic              mm_write,
  output logic [DATA_W-1:0] mm_data
);
  logic [NC-1:0]    req_bit, pend_bit, rest;
  logic [ACK_W-1:0] rest_cnt;
  logic [SRC_W-1:0] own_idx;
  logic             from_owner;

  assign req_bit    = NC'(1) << req_src;
  assign pend_bit   = NC'(1) << cur_pend;
  assign rest       = cur_shr & ~req_bit;
  assign from_owner = (cur_st == LN_M) && ((cur_own & req_bit) != '0);

  always_comb begin
    rest_cnt = '0;
    own_idx  = '0;
    for (int i = 0; i < NC; i++) begin
      rest_cnt = rest_cnt + ACK_W'(rest[i]);
      if (cur_own[i]) own_idx = SRC_W'(i);
    end
  end

  always_comb begin
    wr_en    = 1'b0;
    nx_st    = cur_st;
    nx_own   = cur_own;
    nx_shr   = cur_shr;
    nx_pend  = cur_pend;
    nx_pack  = cur_pack;
    om_go    = 1'b0;
    om_type  = OM_DATA;
    om_dest  = '0;
    om_req   = '0;
    om_data  = '0;
    om_acks  = '0;
    mm_go    = 1'b0;
    mm_write = 1'b0;
    mm_data  = '0;
    unique case (kind)
      SK_MEM: begin
        if (mem_ack) begin
          if (cur_st == LN_SW) begin
            wr_en = 1'b1;
            nx_st = LN_S;
          end else if (cur_st == LN_MIM) begin
            wr_en = 1'b1;
            nx_st = LN_I;
          end
        end else if (cur_st == LN_SM || cur_st == LN_MM) begin
          wr_en   = 1'b1;
          om_go   = 1'b1;
          om_type = OM_DATA;
          om_dest = pend_bit;
          om_req  = cur_pend;
          om_data = mem_data;
          om_acks = (cur_st == LN_MM) ? cur_pack : '0;
          nx_st   = (cur_st == LN_MM) ? LN_M : LN_S;
          nx_pack = '0;
        end
      end
      SK_RSP: begin
        if (cur_st == LN_SD && rsp_src == cur_pend) begin
          wr_en    = 1'b1;
          mm_go    = 1'b1;
          mm_write = 1'b1;
          mm_data  = rsp_data;
          nx_st    = LN_SW;
        end
      end
      SK_REQ: begin
        if (req_type == RQ_GETS) begin
          wr_en = 1'b1;
          if (cur_st == LN_M) begin
            om_go   = 1'b1;
            om_type = OM_FWD_GETS;
            om_dest = cur_own;
            om_req  = req_src;
            nx_shr  = cur_own | req_bit;  // sharers set before owner clear
            nx_own  = '0;
            nx_pend = own_idx;
            nx_st   = LN_SD;
          end else begin
            mm_go   = 1'b1;
            nx_shr  = cur_shr | req_bit;
            nx_pend = req_src;
            nx_st   = LN_SM;
          end
        end else if (req_type == RQ_GETM) begin
          wr_en = 1'b1;
          if (cur_st == LN_M) begin
            om_go   = 1'b1;
            om_type = OM_FWD_GETM;
            om_dest = cur_own;
            om_req  = req_src;
            nx_own  = req_bit;            // old owner dropped, new recorded
          end else begin
            mm_go   = 1'b1;
            om_go   = (rest != '0);
            om_type = OM_INV;
            om_dest = rest;
            om_req  = req_src;
            nx_pack = rest_cnt;
            nx_own  = req_bit;
            nx_shr  = '0;
            nx_pend = req_src;
            nx_st   = LN_MM;
          end
        end else if (req_type == RQ_PUTM) begin
          om_go   = 1'b1;
          om_type = OM_PUT_ACK;
          om_dest = req_bit;
          om_req  = req_src;
          if (from_owner) begin
            wr_en    = 1'b1;
            mm_go    = 1'b1;
            mm_write = 1'b1;
            mm_data  = req_data;
            nx_own   = '0;
            nx_st    = LN_MIM;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl
  import msi_dir_pkg::*;
#(
  parameter int NC     = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int ACK_W  = 4,
  localparam int SRC_W = $clog2(NC),
  localparam int LINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_type,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [SRC_W-1:0]  rsp_src,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              mem_in_valid,
  output logic              mem_in_ready,
  input  logic              mem_in_ack,
  input  logic [ADDR_W-1:0] mem_in_addr,
  input  logic [DATA_W-1:0] mem_in_data,
  output logic              mem_out_valid,
  input  logic              mem_out_ready,
  output logic              mem_out_write,
  output logic [ADDR_W-1:0] mem_out_addr,
  output logic [DATA_W-1:0] mem_out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_type,
  output logic [NC-1:0]     out_dest,
  output logic [SRC_W-1:0]  out_requestor,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [ACK_W-1:0]  out_acks
);
  localparam int NQ = 3;

  line_st_e          peek_st, cur_st, nx_st;
  logic [NC-1:0]     cur_own, cur_shr, nx_own, nx_shr;
  logic [SRC_W-1:0]  cur_pend, nx_pend;
  logic [ACK_W-1:0]  cur_pack, nx_pack;
  logic [NQ-1:0]     want, grant;
  logic              slots_ok, fire, wr_en;
  src_kind_e         sel_kind;
  logic [ADDR_W-1:0] sel_addr;
  logic              om_go, mm_go, mm_write;
  logic [2:0]        om_type;
  logic [NC-1:0]     om_dest;
  logic [SRC_W-1:0]  om_req;
  logic [DATA_W-1:0] om_data, mm_data;
  logic [ACK_W-1:0]  om_acks;

  assign slots_ok = (!out_valid || out_ready) && (!mem_out_valid || mem_out_ready);
  assign want = {req_valid && !is_transient(peek_st), rsp_valid, mem_in_valid};

  msi_dir_pick #(.N(NQ)) u_pick (
    .want     (want),
    .slots_ok (slots_ok),
    .grant    (grant)
  );

  assign mem_in_ready = grant[0];
  assign rsp_ready    = grant[1];
  assign req_ready    = grant[2];
  assign fire         = |grant;

  always_comb begin
    sel_kind = SK_NONE;
    sel_addr = req_addr;
    if (grant[0]) begin
      sel_kind = SK_MEM;
      sel_addr = mem_in_addr;
    end else if (grant[1]) begin
      sel_kind = SK_RSP;
      sel_addr = rsp_addr;
    end else if (grant[2]) begin
      sel_kind = SK_REQ;
    end
  end

  msi_dir_table #(
    .LINES (LINES), .IDX_W (ADDR_W), .NC (NC), .SRC_W (SRC_W), .ACK_W (ACK_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (sel_addr),
    .rd_st    (cur_st),
    .rd_own   (cur_own),
    .rd_shr   (cur_shr),
    .rd_pend  (cur_pend),
    .rd_pack  (cur_pack),
    .peek_idx (req_addr),
    .peek_st  (peek_st),
    .wr_en    (wr_en),
    .wr_idx   (sel_addr),
    .wr_st    (nx_st),
    .wr_own   (nx_own),
    .wr_shr   (nx_shr),
    .wr_pend  (nx_pend),
    .wr_pack  (nx_pack)
  );

  msi_dir_step #(
    .NC (NC), .SRC_W (SRC_W), .DATA_W (DATA_W), .ACK_W (ACK_W)
  ) u_step (
    .kind     (sel_kind),
    .req_type (req_type),
    .req_src  (req_src),
    .req_data (req_data),
    .rsp_src  (rsp_src),
    .rsp_data (rsp_data),
    .mem_ack  (mem_in_ack),
    .mem_data (mem_in_data),
    .cur_st   (cur_st),
    .cur_own  (cur_own),
    .cur_shr  (cur_shr),
    .cur_pend (cur_pend),
    .cur_pack (cur_pack),
    .wr_en    (wr_en),
    .nx_st    (nx_st),
    .nx_own   (nx_own),
    .nx_shr   (nx_shr),
    .nx_pend  (nx_pend),
    .nx_pack  (nx_pack),
    .om_go    (om_go),
    .om_type  (om_type),
    .om_dest  (om_dest),
    .om_req   (om_req),
    .om_data  (om_data),
    .om_acks  (om_acks),
    .mm_go    (mm_go),
    .mm_write (mm_write),
    .mm_data  (mm_data)
  );

  // output registers: valid with reset, payload loads only on a new message
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      mem_out_valid <= 1'b0;
    end else begin
      if (fire && om_go)  out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (fire && mm_go)      mem_out_valid <= 1'b1;
      else if (mem_out_ready) mem_out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fire && om_go) begin
      out_type      <= om_type;
      out_dest      <= om_dest;
      out_requestor <= om_req;
      out_addr      <= sel_addr;
      out_data      <= om_data;
      out_acks      <= om_acks;
    end
    if (fire && mm_go) begin
      mem_out_write <= mm_write;
      mem_out_addr  <= sel_addr;
      mem_out_data  <= mm_data;
    end
  end
endmodule

// File: rtl/msi_dir_chk.sv
module msi_dir_chk
  import msi_dir_pkg::*;
#(
  parameter int NC     = 8,
  parameter int ADDR_W = 4,
  parameter int ACK_W  = 4,
  parameter int SRC_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              mem_in_valid,
  input logic              mem_in_ready,
  input logic              mem_out_valid,
  input logic              mem_out_ready,
  input logic              mem_out_write,
  input logic [ADDR_W-1:0] mem_out_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_type,
  input logic [NC-1:0]     out_dest,
  input logic [SRC_W-1:0]  out_requestor,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ACK_W-1:0]  out_acks,
  input logic              wr_en,
  input line_st_e          wr_st,
  input logic [NC-1:0]     wr_own,
  input logic [NC-1:0]     wr_shr
);
  logic req_fire, rsp_fire, mem_fire;
  assign req_fire = req_valid && req_ready;
  assign rsp_fire = rsp_valid && rsp_ready;
  assign mem_fire = mem_in_valid && mem_in_ready;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !mem_out_valid); // R1

  AST_DATA_SINGLE_DEST: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_type == OM_DATA |-> $countones(out_dest) == 1 && !out_acks[ACK_W-1]); // R2

  AST_INV_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_type == OM_INV |-> !out_dest[out_requestor] && out_dest != '0); // R3

  AST_MODIFIED_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_st == LN_M |-> $countones(wr_own) == 1 && wr_shr == '0); // R4

  AST_FWD_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_type == OM_FWD_GETS || out_type == OM_FWD_GETM)
      |-> $countones(out_dest) == 1); // R5

  AST_INVALID_EMPTY: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_st == LN_I |-> wr_own == '0 && wr_shr == '0); // R6

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_fire, rsp_fire, mem_fire})); // R8

  AST_MEMORY_FIRST: assert property (@(posedge clk) disable iff (rst)
    mem_in_valid && !mem_in_ready |-> !req_fire && !rsp_fire); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dest) &&
      $stable(out_requestor) && $stable(out_addr) && $stable(out_acks)); // R9

  AST_MEM_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_out_valid && !mem_out_ready |=> mem_out_valid && $stable(mem_out_write) &&
      $stable(mem_out_addr)); // R9
endmodule

bind msi_dir_ctrl msi_dir_chk #(
  .NC (NC), .ADDR_W (ADDR_W), .ACK_W (ACK_W), .SRC_W (SRC_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .mem_in_valid  (mem_in_valid),
  .mem_in_ready  (mem_in_ready),
  .mem_out_valid (mem_out_valid),
  .mem_out_ready (mem_out_ready),
  .mem_out_write (mem_out_write),
  .mem_out_addr  (mem_out_addr),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_type      (out_type),
  .out_dest      (out_dest),
  .out_requestor (out_requestor),
  .out_addr      (out_addr),
  .out_acks      (out_acks),
  .wr_en         (wr_en),
  .wr_st         (nx_st),
  .wr_own        (nx_own),
  .wr_shr        (nx_shr)
);

// File: tb/msi_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_dir_ctrl_tb_top;
  localparam int NC = 8, ADDR_W = 4, DATA_W = 32, ACK_W = 4, SRC_W = 3;
  localparam int LINES = 16, NACT = 4, NADDR = 4, NCYC = 4000;
  // bench-side line states and message codes
  localparam int S_I = 0, S_S = 1, S_M = 2, S_SM = 3, S_MM = 4, S_SD = 5, S_SW = 6, S_MIM = 7;
  localparam int T_DATA = 0, T_FGS = 1, T_FGM = 2, T_INV = 3, T_PACK = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_ready; logic [2:0] req_type = 0;
  logic [SRC_W-1:0] req_src = 0; logic [ADDR_W-1:0] req_addr = 0; logic [DATA_W-1:0] req_data = 0;
  logic rsp_valid = 0, rsp_ready; logic [SRC_W-1:0] rsp_src = 0;
  logic [ADDR_W-1:0] rsp_addr = 0; logic [DATA_W-1:0] rsp_data = 0;
  logic mem_in_valid = 0, mem_in_ready, mem_in_ack = 0;
  logic [ADDR_W-1:0] mem_in_addr = 0; logic [DATA_W-1:0] mem_in_data = 0;
  logic mem_out_valid, mem_out_ready = 0, mem_out_write;
  logic [ADDR_W-1:0] mem_out_addr; logic [DATA_W-1:0] mem_out_data;
  logic out_valid, out_ready = 0; logic [2:0] out_type; logic [NC-1:0] out_dest;
  logic [SRC_W-1:0] out_requestor; logic [ADDR_W-1:0] out_addr;
  logic [DATA_W-1:0] out_data; logic [ACK_W-1:0] out_acks;

  msi_dir_ctrl #(.NC(NC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_W(ACK_W)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type), .req_src(req_src),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_src(rsp_src), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data),
    .mem_in_valid(mem_in_valid), .mem_in_ready(mem_in_ready), .mem_in_ack(mem_in_ack),
    .mem_in_addr(mem_in_addr), .mem_in_data(mem_in_data),
    .mem_out_valid(mem_out_valid), .mem_out_ready(mem_out_ready), .mem_out_write(mem_out_write),
    .mem_out_addr(mem_out_addr), .mem_out_data(mem_out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_dest(out_dest),
    .out_requestor(out_requestor), .out_addr(out_addr), .out_data(out_data), .out_acks(out_acks));

  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0, errors = 0; bit done = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model state
  int m_st[LINES]; bit [NC-1:0] m_own[LINES], m_shr[LINES]; int m_pend[LINES], m_pack[LINES];
  bit e_ov, e_mv, e_mw; int e_ot, e_oreq, e_oaddr, e_oacks, e_maddr;
  bit [NC-1:0] e_odest; logic [DATA_W-1:0] e_odata, e_mdata;
  logic [DATA_W-1:0] bmem[LINES];
  typedef struct { int src; int addr; logic [DATA_W-1:0] data; } rsp_t;
  typedef struct { bit ack; int addr; logic [DATA_W-1:0] data; } mr_t;
  rsp_t rq[$]; mr_t mq[$];

  function automatic bit busy(int s);
    return s == S_SM || s == S_MM || s == S_SD || s == S_SW || s == S_MIM;
  endfunction

  function automatic int bits_set(bit [NC-1:0] v);
    int n = 0;
    foreach (v[i]) n += v[i];
    return n;
  endfunction

  function automatic int first_set(bit [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic send_out(int t, bit [NC-1:0] d, int rqs, int a, logic [DATA_W-1:0] dat, int ak);
    e_ov = 1; e_ot = t; e_odest = d; e_oreq = rqs; e_oaddr = a; e_odata = dat; e_oacks = ak;
  endtask

  task automatic send_mem(bit w, int a, logic [DATA_W-1:0] dat);
    e_mv = 1; e_mw = w; e_maddr = a; e_mdata = dat;
  endtask

  task automatic model_mem(input bit ack, input int a, input logic [DATA_W-1:0] dat);
    if (ack) begin
      if (m_st[a] == S_SW) m_st[a] = S_S;
      else if (m_st[a] == S_MIM) m_st[a] = S_I;
    end else if (m_st[a] == S_SM) begin
      send_out(T_DATA, 1 << m_pend[a], m_pend[a], a, dat, 0);
      m_st[a] = S_S;
    end else if (m_st[a] == S_MM) begin
      send_out(T_DATA, 1 << m_pend[a], m_pend[a], a, dat, m_pack[a]);
      m_st[a] = S_M;
    end
  endtask

  task automatic model_req(input int t, input int s, input int a, input logic [DATA_W-1:0] dat);
    bit [NC-1:0] me, others;
    me = 1 << s;
    if (t == 0) begin
      if (m_st[a] == S_M) begin
        send_out(T_FGS, m_own[a], s, a, '0, 0);
        m_pend[a] = first_set(m_own[a]);
        m_shr[a] = m_own[a] | me; m_own[a] = '0; m_st[a] = S_SD;
      end else begin
        send_mem(0, a, '0);
        m_shr[a] |= me; m_pend[a] = s; m_st[a] = S_SM;
      end
    end else if (t == 1) begin
      if (m_st[a] == S_M) begin
        send_out(T_FGM, m_own[a], s, a, '0, 0);
        m_own[a] = me;
      end else begin
        others = m_shr[a] & ~me;
        send_mem(0, a, '0);
        if (others != '0) send_out(T_INV, others, s, a, '0, 0);
        m_pack[a] = bits_set(others);
        m_own[a] = me; m_shr[a] = '0; m_pend[a] = s; m_st[a] = S_MM;
      end
    end else begin
      send_out(T_PACK, me, s, a, '0, 0);
      if (m_st[a] == S_M && m_own[a] == me) begin
        send_mem(1, a, dat);
        m_own[a] = '0; m_st[a] = S_MIM;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    bit req_taken; bit g_mem, g_rsp, g_req, ok;
    string tg;
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = S_I; m_own[i] = '0; m_shr[i] = '0; m_pend[i] = 0; m_pack[i] = 0;
      bmem[i] = 32'h0101_0101 * (i + 1);
    end
    e_ov = 0; e_mv = 0; req_taken = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", out_valid, 0);
    chk("R1", "mem_out_valid in reset", mem_out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "mem_out_valid after reset", mem_out_valid, 0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // drive inputs for the coming edge
      if (!req_valid || req_taken) begin
        req_valid = ($urandom % 4) != 0;
        req_type  = 3'($urandom % 3);
        req_src   = SRC_W'($urandom % NACT);
        req_addr  = ADDR_W'($urandom % NADDR);
        req_data  = $urandom;
      end
      rsp_valid = rq.size() > 0;
      if (rsp_valid) begin
        rsp_src = SRC_W'(rq[0].src); rsp_addr = ADDR_W'(rq[0].addr); rsp_data = rq[0].data;
      end
      mem_in_valid = mq.size() > 0;
      if (mem_in_valid) begin
        mem_in_ack = mq[0].ack; mem_in_addr = ADDR_W'(mq[0].addr); mem_in_data = mq[0].data;
      end
      out_ready     = ($urandom % 4) != 0;
      mem_out_ready = ($urandom % 4) != 0;
      #0.5;
      // expected acceptance
      ok    = (!e_ov || out_ready) && (!e_mv || mem_out_ready);
      g_mem = ok && mem_in_valid;
      g_rsp = ok && !g_mem && rsp_valid;
      g_req = ok && !g_mem && !g_rsp && req_valid && !busy(m_st[req_addr]);
      chk("R8", "mem_in_ready", mem_in_ready, g_mem);
      chk("R8", "rsp_ready", rsp_ready, g_rsp);
      tg = (req_valid && busy(m_st[req_addr])) ? "R7" : "R8";
      chk(tg, "req_ready", req_ready, g_req);
      // registered outputs
      chk("R9", "out_valid", out_valid, e_ov);
      if (e_ov) begin
        case (e_ot)
          T_DATA:  tg = (e_oacks != 0) ? "R3" : "R2";
          T_FGS:   tg = "R5";
          T_FGM:   tg = "R4";
          T_INV:   tg = "R3";
          default: tg = "R6";
        endcase
        chk(tg, "out_type", out_type, e_ot);
        chk(tg, "out_dest", out_dest, e_odest);
        chk(e_ot == T_DATA ? tg : "R9", "out_requestor", out_requestor, e_oreq);
        chk(tg, "out_addr", out_addr, e_oaddr);
        if (e_ot == T_DATA) begin
          chk(tg, "out_data", out_data, e_odata);
          chk(tg, "out_acks", out_acks, e_oacks);
        end
      end
      chk("R9", "mem_out_valid", mem_out_valid, e_mv);
      if (e_mv) begin
        tg = e_mw ? "R6" : "R2";
        chk(tg, "mem_out_write", mem_out_write, e_mw);
        chk(tg, "mem_out_addr", mem_out_addr, e_maddr);
        if (e_mw) chk(tg, "mem_out_data", mem_out_data, e_mdata);
      end
      // the edge: outputs drain into the bench agents
      if (e_ov && out_ready) begin
        if (e_ot == T_FGS) begin
          rsp_t r;
          r.src = first_set(e_odest); r.addr = e_oaddr; r.data = $urandom;
          rq.push_back(r);
        end
        e_ov = 0;
      end
      if (e_mv && mem_out_ready) begin
        mr_t m;
        m.addr = e_maddr; m.ack = e_mw;
        if (e_mw) begin bmem[e_maddr] = e_mdata; m.data = '0; end
        else m.data = bmem[e_maddr];
        mq.push_back(m);
        e_mv = 0;
      end
      // the edge: accepted message updates the model
      if (g_mem) begin
        model_mem(mem_in_ack, int'(mem_in_addr), mem_in_data);
        void'(mq.pop_front());
      end else if (g_rsp) begin
        if (m_st[rsp_addr] == S_SD && m_pend[rsp_addr] == int'(rsp_src)) begin
          send_mem(1, int'(rsp_addr), rsp_data);
          m_st[rsp_addr] = S_SW;
        end
        void'(rq.pop_front());
      end else if (g_req) begin
        model_req(int'(req_type), int'(req_src), int'(req_addr), req_data);
      end
      req_taken = g_req;
    end
    finish_run();
  end
endmodule